// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Unit

This block is a signed arithmetic slice for filter and transform datapaths. Each cycle it takes one operation. It forms a product from two 18-bit two's complement operands and adds that product to a 48-bit running sum. The first operand can be the sum of two inputs, which lets a symmetric FIR tap pair share one multiply. The second operand comes either from an input port or from a small built-in coefficient table. A per-operation control picks the base that the product is added to: the running sum itself, zero, or a 48-bit value from the neighbouring slice. Several slices can therefore be chained into an adder column.

A dot-product mode treats each operand as two packed 9-bit signed halves. The slice multiplies the two high halves together and the two low halves together, and adds both partial products. This gives the two-term sums needed for complex multiplication. With the pipeline enabled, three register stages lie between the inputs and the result: an input stage, a product stage and the accumulator. An operation captured on clock edge n shows up on the result after edge n+2.

Top module: `pmac_unit`

## Requirements
- R1: While `rst_n` is low, `result` and `casc_out` are zero and every pipeline stage holds an operation that adds nothing. Inputs driven during reset have no effect.
- R2: With `acc_sel` = 0 (keep), the new result is the previous result plus the signed product of `in_a` and the second operand.
- R3: With `use_pread` = 1 and `dot_mode` = 0, the first multiplier operand is the 19-bit signed sum `in_a + in_d`. The sum does not overflow, even for extreme operand values.
- R4: With `use_coef` = 1, the second operand is table entry `coef_addr`, and entry k holds the signed value 1000·k − 7000. With `use_coef` = 0 the operand is `in_b`.
- R5: `acc_sel` selects the base added to the product: 0 = previous result, 1 or 3 = zero (load), 2 = `casc_in`. `casc_in` is captured in the same cycle as the operands.
- R6: With `dot_mode` = 1, the product is a[17:9]·b[17:9] + a[8:0]·b[8:0], with every half taken as signed. The pre-adder and `in_d` are ignored.
- R7: The accumulator wraps modulo 2^48 and does not saturate.
- R8: With `PIPE_EN` = 1, an operation presented before clock edge n is visible on `result` after edge n+2, and not before.
- R9: `casc_out` always equals `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 18 | First operand, signed |
| in_d | input | 18 | Pre-adder addend, signed |
| in_b | input | 18 | Second operand from the port, signed |
| coef_addr | input | 4 | Coefficient table index |
| use_coef | input | 1 | Take the second operand from the table |
| use_pread | input | 1 | Add `in_d` to `in_a` before the multiply |
| dot_mode | input | 1 | Two-half dot-product mode |
| acc_sel | input | 2 | Accumulator base: 0 keep, 1/3 zero, 2 cascade |
| casc_in | input | 48 | Cascade sum from the previous slice |
| result | output | 48 | Accumulator value |
| casc_out | output | 48 | Cascade sum to the next slice |

## Verification
Several jobs coincide in one cycle: the accumulate stage applies one operation's base selection while the next operation is being multiplied in the product stage. A load or cascade choice can therefore meet a pending keep on the very next clock. The bench provokes this by changing the mode and the accumulator source on every cycle of a near-exhaustive sweep over operand patterns. Every result is judged against a cycle-exact arithmetic model whose value is compared two operations later.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    typedef enum logic [1:0] {
        ACC_KEEP     = 2'd0,
        ACC_LOAD     = 2'd1,
        ACC_CHAIN    = 2'd2,
        ACC_LOAD_ALT = 2'd3
    } acc_src_e;

    localparam int DEF_OP_W  = 18;
    localparam int DEF_ACC_W = 48;

endpackage

// File: rtl/pmac_coef_rom.sv
module pmac_coef_rom #(
    parameter int W     = 18,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int BASE  = -7000,
    parameter int STEP  = 1000
) (
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  coef
);

    logic [W-1:0] entry [DEPTH];

    // Each entry is computed from its index.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign entry[i] = W'(BASE + i * STEP);
    end

    assign coef = entry[addr];

endmodule

// File: rtl/pmac_preadd.sv
module pmac_preadd #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] d,
    input  logic         en,
    output logic [W:0]   sum
);

    always_comb begin
        if (en) begin
            sum = {a[W-1], a} + {d[W-1], d};
        end else begin
            sum = {a[W-1], a};
        end
    end

endmodule

// File: rtl/pmac_mult.sv
module pmac_mult #(
    parameter int W     = 18,
    parameter int OUT_W = 48
) (
    input  logic [W:0]       pre,
    input  logic [W-1:0]     a_raw,
    input  logic [W-1:0]     b,
    input  logic             dot,
    output logic [OUT_W-1:0] prod
);

    localparam int H = W / 2;

    logic signed [2*W:0]   full;
    logic signed [2*H-1:0] p_hi;
    logic signed [2*H-1:0] p_lo;
    logic signed [2*H:0]   dsum;

    assign full = $signed(pre) * $signed(b);
    assign p_hi = $signed(a_raw[W-1:H]) * $signed(b[W-1:H]);
    assign p_lo = $signed(a_raw[H-1:0]) * $signed(b[H-1:0]);
    assign dsum = {p_hi[2*H-1], p_hi} + {p_lo[2*H-1], p_lo};

    always_comb begin
        if (dot) begin
            prod = {{(OUT_W-2*H-1){dsum[2*H]}}, dsum};
        end else begin
            prod = {{(OUT_W-2*W-1){full[2*W]}}, full};
        end
    end

endmodule

// File: rtl/pmac_accum.sv
module pmac_accum
    import pmac_pkg::*;
#(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_src_e     sel,
    input  logic [W-1:0] casc,
    input  logic [W-1:0] prod,
    output logic [W-1:0] acc
);

    logic [W-1:0] base;

    always_comb begin
        unique case (sel)
            ACC_KEEP:  base = acc;
            ACC_CHAIN: base = casc;
            default:   base = '0;
        endcase
    end

    // The sum wraps modulo 2^W by truncation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= base + prod;
        end
    end

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int OP_W       = DEF_OP_W,
    parameter int ACC_W      = DEF_ACC_W,
    parameter int COEF_DEPTH = 16,
    parameter int COEF_BASE  = -7000,
    parameter int COEF_STEP  = 1000,
    parameter int PIPE_EN    = 1,
    parameter int CAW        = $clog2(COEF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_d,
    input  logic [OP_W-1:0]  in_b,
    input  logic [CAW-1:0]   coef_addr,
    input  logic             use_coef,
    input  logic             use_pread,
    input  logic             dot_mode,
    input  logic [1:0]       acc_sel,
    input  logic [ACC_W-1:0] casc_in,
    output logic [ACC_W-1:0] result,
    output logic [ACC_W-1:0] casc_out
);

    typedef struct packed {
        logic [OP_W-1:0]  a;
        logic [OP_W-1:0]  d;
        logic [OP_W-1:0]  b;
        logic             pread;
        logic             dot;
        acc_src_e         sel;
        logic [ACC_W-1:0] casc;
    } op_stage_t;

    typedef struct packed {
        logic [ACC_W-1:0] prod;
        acc_src_e         sel;
        logic [ACC_W-1:0] casc;
    } prod_stage_t;

    logic [OP_W-1:0]  rom_val;
    op_stage_t        st_in;
    op_stage_t        st_op;
    logic [OP_W:0]    pre_sum;
    logic [ACC_W-1:0] prod_raw;
    prod_stage_t      st_pr_d;
    prod_stage_t      st_pr;
    logic [ACC_W-1:0] acc_q;

    pmac_coef_rom #(
        .W     (OP_W),
        .DEPTH (COEF_DEPTH),
        .AW    (CAW),
        .BASE  (COEF_BASE),
        .STEP  (COEF_STEP)
    ) u_rom (
        .addr (coef_addr),
        .coef (rom_val)
    );

    always_comb begin
        st_in.a     = in_a;
        st_in.d     = in_d;
        st_in.b     = use_coef ? rom_val : in_b;
        st_in.pread = use_pread;
        st_in.dot   = dot_mode;
        st_in.sel   = acc_src_e'(acc_sel);
        st_in.casc  = casc_in;
    end

    if (PIPE_EN != 0) begin : g_in_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_op <= '0;
            end else begin
                st_op <= st_in;
            end
        end
    end else begin : g_in_wire
        assign st_op = st_in;
    end

    pmac_preadd #(
        .W (OP_W)
    ) u_preadd (
        .a   (st_op.a),
        .d   (st_op.d),
        .en  (st_op.pread),
        .sum (pre_sum)
    );

    pmac_mult #(
        .W     (OP_W),
        .OUT_W (ACC_W)
    ) u_mult (
        .pre   (pre_sum),
        .a_raw (st_op.a),
        .b     (st_op.b),
        .dot   (st_op.dot),
        .prod  (prod_raw)
    );

    always_comb begin
        st_pr_d.prod = prod_raw;
        st_pr_d.sel  = st_op.sel;
        st_pr_d.casc = st_op.casc;
    end

    if (PIPE_EN != 0) begin : g_pr_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_pr <= '0;
            end else begin
                st_pr <= st_pr_d;
            end
        end
    end else begin : g_pr_wire
        assign st_pr = st_pr_d;
    end

    pmac_accum #(
        .W (ACC_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (st_pr.sel),
        .casc  (st_pr.casc),
        .prod  (st_pr.prod),
        .acc   (acc_q)
    );

    assign result   = acc_q;
    assign casc_out = acc_q;

endmodule

// File: rtl/pmac_unit_chk.sv
module pmac_unit_chk #(
    parameter int OP_W    = 18,
    parameter int ACC_W   = 48,
    parameter int PIPE_EN = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OP_W-1:0]  in_a,
    input logic [OP_W-1:0]  in_b,
    input logic             use_coef,
    input logic             use_pread,
    input logic             dot_mode,
    input logic [1:0]       acc_sel,
    input logic [ACC_W-1:0] casc_in,
    input logic [ACC_W-1:0] result,
    input logic [ACC_W-1:0] casc_out
);

    // R1: reset clears both outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && casc_out == '0));

    if (PIPE_EN != 0) begin : g_pipe_chk
        logic [1:0]                  n_edges;
        logic [2:0][OP_W-1:0]        a_dl;
        logic [2:0][OP_W-1:0]        b_dl;
        logic [2:0][1:0]             sel_dl;
        logic [2:0]                  coef_dl;
        logic [2:0]                  pread_dl;
        logic [2:0]                  dot_dl;
        logic [2:0][ACC_W-1:0]       casc_dl;
        logic signed [2*OP_W-1:0]    ab_old;
        logic [ACC_W-1:0]            ab_ext;
        logic                        ripe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                n_edges  <= '0;
                a_dl     <= '0;
                b_dl     <= '0;
                sel_dl   <= '0;
                coef_dl  <= '0;
                pread_dl <= '0;
                dot_dl   <= '0;
                casc_dl  <= '0;
            end else begin
                if (n_edges != 2'd3) begin
                    n_edges <= n_edges + 2'd1;
                end
                a_dl     <= {a_dl[1:0], in_a};
                b_dl     <= {b_dl[1:0], in_b};
                sel_dl   <= {sel_dl[1:0], acc_sel};
                coef_dl  <= {coef_dl[1:0], use_coef};
                pread_dl <= {pread_dl[1:0], use_pread};
                dot_dl   <= {dot_dl[1:0], dot_mode};
                casc_dl  <= {casc_dl[1:0], casc_in};
            end
        end

        assign ripe   = (n_edges == 2'd3);
        assign ab_old = $signed(a_dl[2]) * $signed(b_dl[2]);
        assign ab_ext = {{(ACC_W-2*OP_W){ab_old[2*OP_W-1]}}, ab_old};

        // R2: keep with a zero product leaves the sum unchanged
        p_keep_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ripe && sel_dl[2] == 2'd0 && a_dl[2] == '0 && !pread_dl[2])
            |-> $stable(result));

        // R5: load with a zero operand clears the sum
        p_load_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ripe && sel_dl[2] == 2'd1 && !coef_dl[2] && b_dl[2] == '0)
            |-> (result == '0));

        // R5: chain with a zero product passes the cascade value through
        p_chain_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ripe && sel_dl[2] == 2'd2 && a_dl[2] == '0 && !pread_dl[2])
            |-> (result == casc_dl[2]));

        // R8: a plain load appears exactly three cycles after its inputs
        p_load_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ripe && sel_dl[2] == 2'd1 && !coef_dl[2] && !pread_dl[2] && !dot_dl[2])
            |-> (result == ab_ext));
    end

endmodule

bind pmac_unit pmac_unit_chk #(
    .OP_W    (OP_W),
    .ACC_W   (ACC_W),
    .PIPE_EN (PIPE_EN)
) u_pmac_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_a      (in_a),
    .in_b      (in_b),
    .use_coef  (use_coef),
    .use_pread (use_pread),
    .dot_mode  (dot_mode),
    .acc_sel   (acc_sel),
    .casc_in   (casc_in),
    .result    (result),
    .casc_out  (casc_out)
);

// File: tb/test_pmac_unit.sv
`timescale 1ns/1ps
module test_pmac_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] in_a, in_d, in_b;
    logic [3:0]  coef_addr;
    logic        use_coef, use_pread, dot_mode;
    logic [1:0]  acc_sel;
    logic [47:0] casc_in;
    logic [47:0] result, casc_out;

    always #2.5 clk = ~clk;

    pmac_unit i_pmac_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_a      (in_a),
        .in_d      (in_d),
        .in_b      (in_b),
        .coef_addr (coef_addr),
        .use_coef  (use_coef),
        .use_pread (use_pread),
        .dot_mode  (dot_mode),
        .acc_sel   (acc_sel),
        .casc_in   (casc_in),
        .result    (result),
        .casc_out  (casc_out)
    );

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 0;
    int          k = 0;
    logic [47:0] m_acc = '0;
    logic [47:0] exp_hist [0:4095];
    string       tag_hist [0:4095];

    localparam int PAT [8] = '{0, 1, -1, 131071, -131072, 12345, -777, 256};

    function automatic longint sx18(logic [17:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint sx9(logic [8:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [47:0] next_acc(
        logic [47:0] acc, logic [17:0] a, logic [17:0] d, logic [17:0] b,
        logic [3:0] addr, bit uc, bit up, bit dm, logic [1:0] sel, logic [47:0] casc);
        longint      bv;
        logic [17:0] bbits;
        longint      p;
        logic [47:0] base;
        bv    = uc ? (1000 * longint'(addr) - 7000) : sx18(b);
        bbits = 18'(bv);
        if (dm) begin
            p = sx9(a[17:9]) * sx9(bbits[17:9]) + sx9(a[8:0]) * sx9(bbits[8:0]);
        end else if (up) begin
            p = (sx18(a) + sx18(d)) * bv;
        end else begin
            p = sx18(a) * bv;
        end
        case (sel)
            2'd0:    base = acc;
            2'd2:    base = casc;
            default: base = '0;
        endcase
        return base + 48'(p);
    endfunction

    task automatic check(input logic [47:0] got, input logic [47:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic run_op(input logic [17:0] a, input logic [17:0] d, input logic [17:0] b,
                          input logic [3:0] addr, input bit uc, input bit up, input bit dm,
                          input logic [1:0] sel, input logic [47:0] casc, input string tag);
        logic [47:0] exp;
        string       t;
        in_a = a; in_d = d; in_b = b; coef_addr = addr;
        use_coef = uc; use_pread = up; dot_mode = dm;
        acc_sel = sel; casc_in = casc;
        m_acc = next_acc(m_acc, a, d, b, addr, uc, up, dm, sel, casc);
        exp_hist[k] = m_acc;
        tag_hist[k] = tag;
        @(negedge clk);
        // R8: operation k-2 is the newest one visible now
        exp = (k >= 2) ? exp_hist[k-2] : 48'd0;
        t   = (k >= 2) ? tag_hist[k-2] : "R8";
        check(result, exp, t);
        check(casc_out, exp, "R9");
        k++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL R8 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_a = 18'd5; in_d = 18'd3; in_b = 18'd5; coef_addr = '0;
        use_coef = 0; use_pread = 0; dot_mode = 0;
        acc_sel = 2'd1; casc_in = 48'h1234;
        repeat (4) @(negedge clk);
        // R1: inputs during reset have no effect
        check(result, 48'd0, "R1");
        check(casc_out, 48'd0, "R1");
        in_a = '0; in_d = '0; in_b = '0; acc_sel = 2'd0; casc_in = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check(result, 48'd0, "R1");

        // R8: a single load, then idle keep operations
        run_op(18'd5, 18'd0, 18'd7, 4'd0, 0, 0, 0, 2'd1, 48'd0, "R8");
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R8");
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R8");
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R8");

        // R2 R3 R4 R5 R6: sweep of operand patterns and modes
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                for (int m = 0; m < 24; m++) begin
                    logic [1:0] sel;
                    bit         uc, up, dm;
                    string      tg;
                    sel = 2'(m % 3);
                    uc  = ((m / 3) % 2) != 0;
                    up  = ((m / 6) % 2) != 0;
                    dm  = (m / 12) != 0;
                    tg  = dm ? "R6" : up ? "R3" : uc ? "R4" : (sel != 2'd0) ? "R5" : "R2";
                    run_op(18'(PAT[ia]), 18'(PAT[(ia + ib + 1) % 8]), 18'(PAT[ib]),
                           4'((ia * 3 + ib) % 16), uc, up, dm, sel,
                           48'(longint'(PAT[ia]) * 4099 + longint'(PAT[ib])), tg);
                end
            end
        end

        // R4: every table entry loaded through a unit multiplier
        for (int i = 0; i < 16; i++) begin
            run_op(18'd1, '0, '0, 4'(i), 1, 0, 0, 2'd1, 48'd0, "R4");
        end

        // R3: pre-adder at both extremes
        run_op(18'h1FFFF, 18'h1FFFF, 18'h20000, 4'd0, 0, 1, 0, 2'd1, 48'd0, "R3");
        run_op(18'h20000, 18'h20000, 18'h20000, 4'd0, 0, 1, 0, 2'd1, 48'd0, "R3");

        // R6: dot mode with the pre-adder requested and a nonzero addend
        run_op(18'h3FE01, 18'h1FFFF, 18'h201FF, 4'd0, 0, 1, 1, 2'd1, 48'd0, "R6");

        // R7: wrap past the positive limit and back
        run_op(18'd1, '0, 18'd1, 4'd0, 0, 0, 0, 2'd2, 48'h7FFF_FFFF_FFFF, "R7");
        run_op(18'h20000, '0, 18'h1FFFF, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R7");
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd2, 48'hFFFF_FFFF_FFFF, "R7");
        run_op(18'd2, '0, 18'd3, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R7");

        // Drain the pipeline
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R8");
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R8");
        run_op('0, '0, '0, 4'd0, 0, 0, 0, 2'd0, 48'd0, "R8");

        finished = 1;
        summary();
        $finish;
    end

endmodule